// File: doc/BRIEF.md
# D-Channel Contention Priority Controller

This block sits in a terminal attached to a shared point-to-multipoint passive bus. It decides when the terminal may start sending a layer-2 frame on the common D-channel, and it watches for collisions while the frame is on the line. The line side presents one D-bit period per `bit_stb` cycle. On each such strobe the block sees the echoed bit from the far end (`echo_bit`) and the bit this terminal placed on the line (`tx_dbit`).

While idle, a priority counter counts runs of consecutive echoed ones. The required run length is set at two levels:

- **User class.** The class input selects the high class (8 or 9) or the low class (10 or 11). The class decides which pair of values applies, so it takes precedence.
- **Internal level.** An internal level chooses the lower or the higher value inside that pair. The level steps up after each successful frame, which gives other terminals a turn.

When the run reaches the active count and a frame is pending, the block grants transmission and pulses the opening-flag strobe on that same strobe. If an echoed bit differs from the sent bit during transmission, the block does four things: it withdraws the grant, raises a sticky interrupt, pulses a discard for the rest of the packet, and suspends counting until the next frame pulse. At that frame pulse it also clears the access acknowledge.

Top module: `dch_prio_ctrl`

## Requirements
- R1: While not transmitting and with no collision pending, each `bit_stb` with `echo_bit`=1 raises the priority count by one, and each `bit_stb` with `echo_bit`=0 resets it to zero.
- R2: With `class_low`=0 the terminal count is 8 (level low) or 9 (level high). With `class_low`=1 it is 10 or 11.
- R3: After reset the level is low. A frame that ends successfully sets the level high. The level returns to low on the strobe where the count reaches the higher value of the class.
- R4: On the strobe where the updated count is at or above the active terminal count and `tx_req`=1, the next cycle shows `tx_grant`=1, `access_ack`=1 and a one-cycle `flag_start`=1. The count then restarts from zero.
- R5: With `tx_req`=0 the count saturates at the active terminal count. Raising `tx_req` then starts transmission on the next strobe with `echo_bit`=1. The count does not advance while `tx_grant`=1.
- R6: During transmission, a strobe with `echo_bit`≠`tx_dbit` drops `tx_grant` in the next cycle, sets `coll_irq` and gives a one-cycle `fifo_discard`. A collision outranks `eop` on the same strobe, so the level is not raised.
- R7: After a collision, `access_ack` stays 1 until the next `frame_pulse` and is 0 after it. No transmission can start before that frame pulse. Counting then resumes from zero.
- R8: `coll_irq` stays 1 until `irq_clr`=1. A collision in the same cycle as `irq_clr` leaves it set.
- R9: A strobe with `eop`=1 during transmission and no collision drops `tx_grant` and `access_ack` in the next cycle.
- R10: While `rst_n`=0 all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One D-bit period elapsed; qualifies echo_bit, tx_dbit and eop |
| echo_bit | input | 1 | Echoed bit received from the bus |
| tx_dbit | input | 1 | D bit this terminal sent in the same period |
| frame_pulse | input | 1 | Line frame boundary |
| class_low | input | 1 | User class: 0 selects 8/9, 1 selects 10/11 |
| tx_req | input | 1 | A frame is waiting in the transmit FIFO |
| eop | input | 1 | Last bit of the packet is being sent |
| irq_clr | input | 1 | Clears the collision interrupt |
| tx_grant | output | 1 | Terminal owns the D-channel |
| flag_start | output | 1 | One-cycle strobe to send the opening flag |
| coll_irq | output | 1 | Sticky collision interrupt |
| access_ack | output | 1 | D-channel access acknowledged |
| fifo_discard | output | 1 | One-cycle strobe to drop the rest of the packet |

## Verification
The collision check and the end-of-packet check both act on the same transmitting strobe, so they can fall in the same cycle. The bench provokes this with a directed strobe that carries both `eop`=1 and a mismatched echo, and random traffic adds more overlaps. The result is judged on the following frame: the collision must win. That means the discard and interrupt fire and the acknowledge stays high until the frame pulse. It also means the level is not raised, which the bench shows when the next grant arrives after the lower run length rather than the higher one.

// File: rtl/dch_prio_pkg.sv
package dch_prio_pkg;
   // width needed to hold a count value up to and including max_v
   function automatic int unsigned cnt_width(input int unsigned max_v);
      return $clog2(max_v + 1);
   endfunction
endpackage

// File: rtl/dch_term_sel.sv
module dch_term_sel #(
   parameter int unsigned HI_BASE = 8,
   parameter int unsigned LO_BASE = 10,
   parameter int unsigned CW      = 4
) (
   input  logic          class_low,
   input  logic          level_hi,
   output logic [CW-1:0] term,
   output logic [CW-1:0] term_top
);
   localparam logic [CW-1:0] HI_L = CW'(HI_BASE);
   localparam logic [CW-1:0] LO_L = CW'(LO_BASE);

   if (LO_BASE <= HI_BASE + 1) begin : g_bad_order
      $error("dch_term_sel: low class must need a longer run than high class");
   end
   if (HI_BASE == 0) begin : g_bad_zero
      $error("dch_term_sel: HI_BASE must be nonzero");
   end

   logic [CW-1:0] base;
   always_comb begin
      base     = class_low ? LO_L : HI_L;
      term_top = base + CW'(1);
      term     = level_hi ? term_top : base;
   end
endmodule

// File: rtl/dch_prio_counter.sv
module dch_prio_counter #(
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_stb,
   input  logic          echo_bit,
   input  logic          live,
   input  logic          zero,
   input  logic [CW-1:0] term,
   output logic [CW-1:0] cnt_q,
   output logic [CW-1:0] cnt_nxt
);
   always_comb begin
      if (!echo_bit)          cnt_nxt = '0;
      else if (cnt_q >= term) cnt_nxt = term;
      else                    cnt_nxt = cnt_q + CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (zero)             cnt_q <= '0;
      else if (bit_stb && live)  cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/dch_coll_ctl.sv
module dch_coll_ctl #(
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_stb,
   input  logic          echo_bit,
   input  logic          tx_dbit,
   input  logic          eop,
   input  logic          frame_pulse,
   input  logic          irq_clr,
   input  logic          tx_req,
   input  logic [CW-1:0] cnt_nxt,
   input  logic [CW-1:0] term,
   input  logic [CW-1:0] term_top,
   output logic          live,
   output logic          zero,
   output logic          level_hi,
   output logic          tx_grant,
   output logic          flag_start,
   output logic          coll_irq,
   output logic          access_ack,
   output logic          fifo_discard
);
   logic pend_q;
   logic start, coll, done, lvl_drop;

   always_comb begin
      live     = !tx_grant && !pend_q;
      start    = bit_stb && live && tx_req && (cnt_nxt >= term);
      coll     = bit_stb && tx_grant && (echo_bit != tx_dbit);
      done     = bit_stb && tx_grant && !coll && eop;
      lvl_drop = bit_stb && live && (cnt_nxt == term_top);
      zero     = start || coll || done;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_grant     <= 1'b0;
         flag_start   <= 1'b0;
         coll_irq     <= 1'b0;
         access_ack   <= 1'b0;
         fifo_discard <= 1'b0;
         pend_q       <= 1'b0;
         level_hi     <= 1'b0;
      end else begin
         flag_start   <= start;
         fifo_discard <= coll;
         if (start)               tx_grant <= 1'b1;
         else if (coll || done)   tx_grant <= 1'b0;
         if (coll)                coll_irq <= 1'b1;
         else if (irq_clr)        coll_irq <= 1'b0;
         if (start)                          access_ack <= 1'b1;
         else if (done)                      access_ack <= 1'b0;
         else if (frame_pulse && pend_q)     access_ack <= 1'b0;
         if (coll)                           pend_q <= 1'b1;
         else if (frame_pulse)               pend_q <= 1'b0;
         if (done)                level_hi <= 1'b1;
         else if (lvl_drop)       level_hi <= 1'b0;
      end
   end
endmodule

// File: rtl/dch_prio_ctrl.sv
module dch_prio_ctrl #(
   parameter int unsigned HI_BASE = 8,
   parameter int unsigned LO_BASE = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_stb,
   input  logic echo_bit,
   input  logic tx_dbit,
   input  logic frame_pulse,
   input  logic class_low,
   input  logic tx_req,
   input  logic eop,
   input  logic irq_clr,
   output logic tx_grant,
   output logic flag_start,
   output logic coll_irq,
   output logic access_ack,
   output logic fifo_discard
);
   localparam int unsigned CW = dch_prio_pkg::cnt_width(LO_BASE + 1);

   logic [CW-1:0] term, term_top, cnt_q, cnt_nxt;
   logic          live, zero, level_hi;

   dch_term_sel #(.HI_BASE(HI_BASE), .LO_BASE(LO_BASE), .CW(CW)) u_term (
      .class_low(class_low), .level_hi(level_hi),
      .term(term), .term_top(term_top));

   dch_prio_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .echo_bit(echo_bit),
      .live(live), .zero(zero), .term(term),
      .cnt_q(cnt_q), .cnt_nxt(cnt_nxt));

   dch_coll_ctl #(.CW(CW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .echo_bit(echo_bit),
      .tx_dbit(tx_dbit), .eop(eop), .frame_pulse(frame_pulse),
      .irq_clr(irq_clr), .tx_req(tx_req), .cnt_nxt(cnt_nxt),
      .term(term), .term_top(term_top), .live(live), .zero(zero),
      .level_hi(level_hi), .tx_grant(tx_grant), .flag_start(flag_start),
      .coll_irq(coll_irq), .access_ack(access_ack),
      .fifo_discard(fifo_discard));
endmodule

// File: rtl/dch_prio_ctrl_chk.sv
module dch_prio_ctrl_chk #(
   parameter int unsigned CW = 4,
   parameter int unsigned LO_BASE = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bit_stb,
   input logic          echo_bit,
   input logic          tx_dbit,
   input logic          irq_clr,
   input logic          tx_grant,
   input logic          flag_start,
   input logic          coll_irq,
   input logic          access_ack,
   input logic          fifo_discard,
   input logic [CW-1:0] cnt_q
);
   a_r4_flag_with_grant: assert property (@(posedge clk) disable iff (!rst_n)
      flag_start |-> tx_grant && access_ack);
   a_r6_coll_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_grant && bit_stb && (echo_bit != tx_dbit)) |=> (!tx_grant && fifo_discard && coll_irq));
   a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (coll_irq && !irq_clr) |=> coll_irq);
   a_r7_ack_while_tx: assert property (@(posedge clk) disable iff (!rst_n)
      tx_grant |-> access_ack);
   a_r6_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flag_start, fifo_discard}));
   a_r5_no_count_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
      tx_grant |-> cnt_q == '0);
   a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(LO_BASE + 1));
endmodule

bind dch_prio_ctrl dch_prio_ctrl_chk #(.CW(CW), .LO_BASE(LO_BASE)) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .echo_bit(echo_bit),
   .tx_dbit(tx_dbit), .irq_clr(irq_clr), .tx_grant(tx_grant),
   .flag_start(flag_start), .coll_irq(coll_irq), .access_ack(access_ack),
   .fifo_discard(fifo_discard), .cnt_q(cnt_q));

// File: tb/dch_prio_ctrl_bench.sv
`timescale 1ns/1ps
module dch_prio_ctrl_bench;
   logic clk = 1'b0, rst_n = 1'b0;
   logic bit_stb = 0, echo_bit = 0, tx_dbit = 0, frame_pulse = 0;
   logic class_low = 0, tx_req = 0, eop = 0, irq_clr = 0;
   logic tx_grant, flag_start, coll_irq, access_ack, fifo_discard;
   int   n_run = 0, n_fail = 0;
   bit   finished = 0;

   always #4 clk = ~clk;

   dch_prio_ctrl u_dch_prio_ctrl (.*);

   // reference model
   int m_cnt = 0;
   bit m_tx = 0, m_lvl = 0, m_pend = 0, m_irq = 0, m_ack = 0, m_fs = 0, m_disc = 0;

   function automatic int term_of(bit cls, bit lvl);
      return (cls ? 10 : 8) + (lvl ? 1 : 0);
   endfunction

   function automatic void model_step();
      int  t = term_of(class_low, m_lvl);
      int  nc;
      bit  c = 0;
      bit  old_pend = m_pend;
      m_fs = 0; m_disc = 0;
      if (bit_stb) begin
         if (!m_tx && !m_pend) begin
            nc = !echo_bit ? 0 : ((m_cnt >= t) ? t : m_cnt + 1);
            if (nc == term_of(class_low, 1'b1)) m_lvl = 0;
            if (tx_req && nc >= t) begin
               m_tx = 1; m_fs = 1; m_ack = 1; m_cnt = 0;
            end else m_cnt = nc;
         end else if (m_tx) begin
            if (echo_bit != tx_dbit) begin
               c = 1; m_tx = 0; m_disc = 1; m_pend = 1; m_cnt = 0;
            end else if (eop) begin
               m_tx = 0; m_lvl = 1; m_ack = 0; m_cnt = 0;
            end
         end
      end
      if (frame_pulse && old_pend) begin m_ack = 0; m_pend = 0; end
      if (c) m_irq = 1; else if (irq_clr) m_irq = 0;
   endfunction

   task automatic chk1(string tag, string nm, logic got, bit exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s got %b exp %b at %0t", tag, nm, got, exp, $time);
      end
   endtask

   task automatic compare(string tag);
      chk1(tag, "tx_grant(R4)",     tx_grant,     m_tx);
      chk1(tag, "flag_start(R4)",   flag_start,   m_fs);
      chk1(tag, "coll_irq(R8)",     coll_irq,     m_irq);
      chk1(tag, "access_ack(R7)",   access_ack,   m_ack);
      chk1(tag, "fifo_discard(R6)", fifo_discard, m_disc);
   endtask

   // inputs are set at the negedge; the design registers them at the next
   // posedge, and the outputs are sampled at the following negedge
   task automatic cyc(string tag);
      model_step();
      @(posedge clk); @(negedge clk);
      compare(tag);
      bit_stb = 0; frame_pulse = 0; eop = 0; irq_clr = 0;
   endtask

   task automatic dbit(string tag, bit e, bit d, bit last);
      bit_stb = 1; echo_bit = e; tx_dbit = d; eop = last;
      cyc(tag);
   endtask

   task automatic ones(string tag, int n);
      for (int i = 0; i < n; i++) dbit(tag, 1, 1, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      compare("R10 reset");
      rst_n = 1;
      @(negedge clk);

      // R1/R2/R4: high class, low level: start on the 8th one
      tx_req = 1;
      ones("R2 no start before 8", 7);
      chk1("R2", "flag_before_8", flag_start, 1'b0);
      ones("R4 start at 8", 1);
      chk1("R4", "flag_at_8", flag_start, 1'b1);
      tx_req = 0;
      ones("R5 tx bits", 3);
      dbit("R9 eop", 1, 1, 1);
      chk1("R9", "grant_after_eop", tx_grant, 1'b0);

      // R3: level high, run of 9 needed
      tx_req = 1;
      ones("R3 hi level", 8);
      chk1("R3", "no_flag_at_8_hi", flag_start, 1'b0);
      ones("R3 hi level", 1);
      chk1("R3", "flag_at_9_hi", flag_start, 1'b1);
      dbit("R9 eop", 0, 0, 1);

      // R3/R5: saturate with no request, level drops at 9
      tx_req = 0;
      ones("R5 saturate", 12);
      tx_req = 1;
      ones("R5 start from saturation", 1);
      chk1("R5", "flag_after_saturate", flag_start, 1'b1);

      // R6: collision and eop on the same strobe
      dbit("R6 coll+eop", 1, 0, 1);
      chk1("R6", "discard", fifo_discard, 1'b1);
      chk1("R7", "ack_held", access_ack, 1'b1);
      ones("R7 suspended", 12);
      chk1("R7", "no_grant_before_fp", tx_grant, 1'b0);
      frame_pulse = 1; cyc("R7 frame pulse");
      chk1("R7", "ack_cleared", access_ack, 1'b0);
      ones("R6 level not raised", 8);
      chk1("R6", "flag_at_8_after_coll", flag_start, 1'b1);

      // R8: collision with irq_clr in the same cycle keeps irq
      irq_clr = 1; dbit("R8 coll+clr", 0, 1, 0);
      chk1("R8", "irq_kept", coll_irq, 1'b1);
      irq_clr = 1; cyc("R8 clear");
      chk1("R8", "irq_cleared", coll_irq, 1'b0);
      frame_pulse = 1; cyc("R7 fp");

      // R1/R2: low class, a zero restarts the run
      class_low = 1;
      ones("R1 partial", 5);
      dbit("R1 zero", 0, 0, 0);
      ones("R2 low class", 9);
      chk1("R2", "no_flag_at_9_low", flag_start, 1'b0);
      ones("R2 low class", 1);
      chk1("R1", "flag_at_10_low", flag_start, 1'b1);
      dbit("R9 eop", 1, 1, 1);

      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         bit_stb     = ($urandom % 4) != 0;
         tx_dbit     = $urandom % 2;
         if (tx_grant) echo_bit = (($urandom % 20) == 0) ? !tx_dbit : tx_dbit;
         else          echo_bit = ($urandom % 12) != 0;
         eop         = ($urandom % 8) == 0;
         tx_req      = ($urandom % 10) < 7;
         frame_pulse = ($urandom % 16) == 0;
         irq_clr     = ($urandom % 20) == 0;
         if (($urandom % 100) == 0) class_low = !class_low;
         cyc("R4/R6 random");
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule